// File: doc/BRIEF.md
# Cluster Responder Detection Unit

This unit sits between a 16x16 cluster of bit-level processing elements and the cluster's controller. It takes the response bit of every element and reduces it to the summaries the controller needs for associative searches. These are a some/none flag, a mask of the rows holding responders, a mask of the columns holding responders, and the address of the lowest-addressed responder. All of these are combinational, so the controller can branch on them in the same cycle.

The controller can also ask for a population count. A start command takes a snapshot of the 256 response bits into a shift chain and clears an accumulator. The chain is then shifted one bit per cycle into the accumulator, which adds one for every set bit. After the whole chain has passed, a done strobe is raised for one cycle, and the result holds until the next start.

In the other direction, the unit drives one enable per element. The enables come either from a row select mask and a column select mask written by the controller, or from a single encoded address that enables exactly one element.

Top module: `cluster_resp_unit`

## Requirements
- R1: `any_o` is 1 in the same cycle as `resp_i` whenever at least one bit of `resp_i` is 1, and 0 otherwise. Element (r,c) is bit r*16+c of `resp_i`.
- R2: `row_hit_o[r]` is 1 exactly when some element in row r responds. `col_hit_o[c]` is 1 exactly when some element in column c responds. Both are combinational.
- R3: When any element responds, `first_addr_o` gives the lowest-indexed responder of `resp_i`. The row index sits in bits 7:4 and the column index in bits 3:0, and `first_valid_o` is 1.
- R4: When no element responds, `first_addr_o` is 0 and `first_valid_o` is 0.
- R5: A `count_start_i` pulse sampled at clock edge E0 snapshots `resp_i` and clears `count_o` to 0. After 256 further edges, `count_o` equals the number of set bits in the snapshot and `done_o` is 1 for exactly that one cycle.
- R6: After `done_o`, `count_o` keeps its value, whatever `resp_i` does, until the next `count_start_i`. A start given during a count restarts it from the new snapshot.
- R7: With `addr_mode_i` = 0, `enable_o[r*16+c]` = `row_sel_i[r]` AND `col_sel_i[c]`.
- R8: With `addr_mode_i` = 1, `enable_o` has exactly one bit set: element (`addr_i[7:4]`, `addr_i[3:0]`). The select masks are then ignored.
- R9: After reset, `count_o` is 0 and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| resp_i | input | 256 | Response bit of each element, index r*16+c |
| count_start_i | input | 1 | Clear the accumulator and start a shift count |
| row_sel_i | input | 16 | Row select mask from the controller |
| col_sel_i | input | 16 | Column select mask from the controller |
| addr_mode_i | input | 1 | 1: enable the single element at addr_i |
| addr_i | input | 8 | Encoded element address {row, column} |
| any_o | output | 1 | Some/none response flag |
| row_hit_o | output | 16 | Rows holding at least one responder |
| col_hit_o | output | 16 | Columns holding at least one responder |
| first_addr_o | output | 8 | Address of the lowest-indexed responder |
| first_valid_o | output | 1 | A responder exists |
| count_o | output | 9 | Responder count accumulator |
| done_o | output | 1 | One-cycle strobe at the end of a count |
| enable_o | output | 256 | Per-element execute enables |

## Verification
The flag, the hit masks, the first address and the enables are combinational. The bench therefore checks them at the falling edge in the same cycle it drives the inputs, and settles the inputs half a cycle before that. A count starts at the rising edge where the start pulse is sampled. Its result and done strobe are due exactly 256 rising edges later, so the bench counts those edges and samples at the following falling edge. It then samples one cycle later to see that done has dropped and the value held. Single-bit sweeps cover every element position for the summaries and the single-address enable. Pseudo-random dense and sparse patterns cover the priority order and the count.

// File: rtl/cru_pkg.sv
package cru_pkg;
  parameter int unsigned CRU_ROWS = 16;
  parameter int unsigned CRU_COLS = 16;
endpackage

// File: rtl/cru_prio_enc.sv
module cru_prio_enc #(
  parameter int unsigned W  = 16,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          valid_o
);
  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
    valid_o = |req_i;
  end
endmodule

// File: rtl/cru_hit_map.sv
module cru_hit_map #(
  parameter int unsigned ROWS = 16,
  parameter int unsigned COLS = 16,
  localparam int unsigned N = ROWS * COLS
) (
  input  logic [N-1:0]    resp_i,
  output logic [ROWS-1:0] row_hit_o,
  output logic [COLS-1:0] col_hit_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_hit_o[r] = |resp_i[r*COLS +: COLS];
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] col_bits;
    for (genvar r = 0; r < ROWS; r++) begin : g_bit
      assign col_bits[r] = resp_i[r*COLS + c];
    end
    assign col_hit_o[c] = |col_bits;
  end
endmodule

// File: rtl/cru_pop_shift.sv
module cru_pop_shift #(
  parameter int unsigned N = 256,
  localparam int unsigned CNTW = $clog2(N + 1),
  localparam int unsigned BW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [N-1:0]    snap_i,
  output logic [CNTW-1:0] count_o,
  output logic            done_o
);
  localparam logic [BW-1:0] LAST = BW'(N - 1);

  logic [N-1:0]    chain_q;
  logic [BW-1:0]   bit_q;
  logic            busy_q;
  logic [CNTW-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      bit_q   <= '0;
      busy_q  <= 1'b0;
      acc_q   <= '0;
      done_o  <= 1'b0;
    end else if (start_i) begin
      chain_q <= snap_i;
      bit_q   <= '0;
      busy_q  <= 1'b1;
      acc_q   <= '0;
      done_o  <= 1'b0;
    end else if (busy_q) begin
      chain_q <= chain_q >> 1;
      acc_q   <= acc_q + {{(CNTW-1){1'b0}}, chain_q[0]};
      bit_q   <= bit_q + 1'b1;
      if (bit_q == LAST) begin
        busy_q <= 1'b0;
        done_o <= 1'b1;
      end
    end else begin
      done_o <= 1'b0;
    end
  end

  assign count_o = acc_q;

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_count_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNTW'(N));
  p_count_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> $stable(count_o));
  p_start_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (count_o == '0));
endmodule

// File: rtl/cru_enable_gen.sv
module cru_enable_gen #(
  parameter int unsigned ROWS = 16,
  parameter int unsigned COLS = 16,
  localparam int unsigned N  = ROWS * COLS,
  localparam int unsigned RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int unsigned CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic [ROWS-1:0] row_sel_i,
  input  logic [COLS-1:0] col_sel_i,
  input  logic            addr_mode_i,
  input  logic [RW-1:0]   addr_row_i,
  input  logic [CW-1:0]   addr_col_i,
  output logic [N-1:0]    enable_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic hit_addr;
      assign hit_addr = (addr_row_i == RW'(r)) && (addr_col_i == CW'(c));
      assign enable_o[r*COLS + c] = addr_mode_i ? hit_addr
                                                : (row_sel_i[r] & col_sel_i[c]);
    end
  end
endmodule

// File: rtl/cluster_resp_unit.sv
module cluster_resp_unit
  import cru_pkg::*;
#(
  parameter int unsigned ROWS = CRU_ROWS,
  parameter int unsigned COLS = CRU_COLS,
  localparam int unsigned N     = ROWS * COLS,
  localparam int unsigned RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int unsigned CW    = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int unsigned ADDRW = RW + CW,
  localparam int unsigned CNTW  = $clog2(N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     resp_i,
  input  logic             count_start_i,
  input  logic [ROWS-1:0]  row_sel_i,
  input  logic [COLS-1:0]  col_sel_i,
  input  logic             addr_mode_i,
  input  logic [ADDRW-1:0] addr_i,
  output logic             any_o,
  output logic [ROWS-1:0]  row_hit_o,
  output logic [COLS-1:0]  col_hit_o,
  output logic [ADDRW-1:0] first_addr_o,
  output logic             first_valid_o,
  output logic [CNTW-1:0]  count_o,
  output logic             done_o,
  output logic [N-1:0]     enable_o
);
  logic [RW-1:0]   first_row;
  logic            row_valid;
  logic [COLS-1:0] first_row_bits;
  logic [CW-1:0]   first_col;
  logic            col_valid;

  cru_hit_map #(.ROWS(ROWS), .COLS(COLS)) u_hit_map (
    .resp_i    (resp_i),
    .row_hit_o (row_hit_o),
    .col_hit_o (col_hit_o)
  );

  cru_prio_enc #(.W(ROWS)) u_row_enc (
    .req_i   (row_hit_o),
    .idx_o   (first_row),
    .valid_o (row_valid)
  );

  // column search is limited to the first responding row
  always_comb begin
    first_row_bits = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (first_row == RW'(r)) first_row_bits = resp_i[r*COLS +: COLS];
    end
  end

  cru_prio_enc #(.W(COLS)) u_col_enc (
    .req_i   (first_row_bits),
    .idx_o   (first_col),
    .valid_o (col_valid)
  );

  assign any_o         = |resp_i;
  assign first_valid_o = row_valid;
  assign first_addr_o  = row_valid ? {first_row, first_col} : '0;

  cru_pop_shift #(.N(N)) u_pop (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (count_start_i),
    .snap_i  (resp_i),
    .count_o (count_o),
    .done_o  (done_o)
  );

  cru_enable_gen #(.ROWS(ROWS), .COLS(COLS)) u_en (
    .row_sel_i   (row_sel_i),
    .col_sel_i   (col_sel_i),
    .addr_mode_i (addr_mode_i),
    .addr_row_i  (addr_i[ADDRW-1:CW]),
    .addr_col_i  (addr_i[CW-1:0]),
    .enable_o    (enable_o)
  );

  p_any_rows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o == (|row_hit_o));
  p_rows_cols_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|row_hit_o) == (|col_hit_o));
  p_first_is_resp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_valid_o |-> (resp_i[first_addr_o] && col_valid && col_hit_o[first_col]));
  p_none_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_o |-> (!first_valid_o && first_addr_o == '0));
  p_single_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_mode_i |-> ($countones(enable_o) == 1 && enable_o[addr_i]));
endmodule

// File: tb/cluster_resp_unit_bench.sv
`timescale 1ns/1ps
module cluster_resp_unit_bench;
  localparam int N = 256;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] resp = '0;
  logic         start = 1'b0;
  logic [15:0]  row_sel = '0;
  logic [15:0]  col_sel = '0;
  logic         addr_mode = 1'b0;
  logic [7:0]   addr = '0;
  logic         any;
  logic [15:0]  row_hit, col_hit;
  logic [7:0]   first_addr;
  logic         first_valid;
  logic [8:0]   count;
  logic         done;
  logic [N-1:0] enable;

  int checks = 0;
  int fails  = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2.5 clk = ~clk;

  cluster_resp_unit u_cluster_resp_unit (
    .clk_i(clk), .rst_ni(rst_n), .resp_i(resp), .count_start_i(start),
    .row_sel_i(row_sel), .col_sel_i(col_sel), .addr_mode_i(addr_mode),
    .addr_i(addr), .any_o(any), .row_hit_o(row_hit), .col_hit_o(col_hit),
    .first_addr_o(first_addr), .first_valid_o(first_valid), .count_o(count),
    .done_o(done), .enable_o(enable)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] next_pat();
    logic [N-1:0] p;
    for (int w = 0; w < N / 32; w++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      p[w*32 +: 32] = lfsr;
    end
    return p;
  endfunction

  task automatic check_summary(input logic [N-1:0] p);
    logic [15:0] er, ec;
    logic [7:0]  ea;
    logic        ev;
    er = '0; ec = '0; ea = '0; ev = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (p[k]) begin
        er[k / 16] = 1'b1;
        ec[k % 16] = 1'b1;
        ev = 1'b1;
        ea = {4'(k / 16), 4'(k % 16)};
      end
    end
    resp = p;
    #1;
    chk("R1 any", N'(any), N'(ev));
    chk("R2 row mask", N'(row_hit), N'(er));
    chk("R2 col mask", N'(col_hit), N'(ec));
    if (ev) chk("R3 first addr", N'({first_valid, first_addr}), N'({1'b1, ea}));
    else    chk("R4 empty addr", N'({first_valid, first_addr}), N'(9'd0));
  endtask

  task automatic run_count(input logic [N-1:0] p);
    int pop;
    pop = 0;
    for (int k = 0; k < N; k++) pop += int'(p[k]);
    @(negedge clk);
    resp = p;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    resp = ~p;
    chk("R5 cleared", N'(count), N'(0));
    repeat (255) @(posedge clk);
    @(negedge clk);
    chk("R5 not yet done", N'(done), N'(0));
    @(negedge clk);
    chk("R5 done strobe", N'(done), N'(1));
    chk("R5 count", N'(count), N'(pop));
    @(negedge clk);
    chk("R5 done one cycle", N'(done), N'(0));
    resp = next_pat();
    repeat (5) @(negedge clk);
    chk("R6 hold", N'(count), N'(pop));
  endtask

  task automatic check_enable();
    logic [N-1:0] e;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        e[r*16 + c] = addr_mode ? (addr == {4'(r), 4'(c)}) : (row_sel[r] & col_sel[c]);
    #1;
    if (addr_mode) chk("R8 single enable", enable, e);
    else           chk("R7 mask enable", enable, e);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] p;
    repeat (3) @(negedge clk);
    chk("R9 reset count", N'(count), N'(0));
    chk("R9 reset done", N'(done), N'(0));
    rst_n = 1'b1;
    @(negedge clk);

    check_summary('0);
    for (int k = 0; k < N; k++) begin
      p = '0; p[k] = 1'b1;
      check_summary(p);
      check_summary(p | (p << 17) | (p << 200));
    end
    for (int t = 0; t < 40; t++) begin
      p = next_pat();
      check_summary(p);
      check_summary(p & next_pat() & next_pat() & next_pat());
    end

    run_count('0);
    run_count('1);
    p = '0; p[N-1] = 1'b1;
    run_count(p);
    run_count(next_pat());
    run_count(next_pat() & next_pat());

    // restart during a count
    @(negedge clk);
    resp = '1; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    p = '0; p[3] = 1'b1; p[77] = 1'b1; p[250] = 1'b1;
    resp = p; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    repeat (256) @(posedge clk);
    @(negedge clk);
    chk("R6 restart done", N'(done), N'(1));
    chk("R6 restart count", N'(count), N'(3));

    addr_mode = 1'b0;
    for (int t = 0; t < 64; t++) begin
      row_sel = 16'(t * 16'h1357) ^ lfsr[15:0];
      col_sel = lfsr[31:16] ^ 16'(t);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      check_enable();
    end
    row_sel = '1; col_sel = '1; check_enable();
    row_sel = '0; col_sel = '1; check_enable();
    addr_mode = 1'b1;
    row_sel = '0; col_sel = '0;
    for (int a = 0; a < 256; a++) begin
      addr = 8'(a);
      check_enable();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule